// File: doc/BRIEF.md
# SPI Status Register Write-Protect Controller

This block is the slave-side status logic of a serial flash device. It watches chip select, serial clock and serial data in on an SPI bus. It decodes an 8-bit opcode and an optional data byte, and it keeps the protection state: three block-protect bits, a lock bit and a write-enable latch. The rest of the device sees the protect bits on dedicated outputs. Software reads the whole status byte back through serial data out.

Bus inputs are synchronized into the local clock domain. All decisions are made there. A status write takes effect only when chip select returns high. At that moment the block looks at the lock bit together with the level of a hardware write-protect pin. With the pin low and the lock bit set, every status write is refused. With the pin low and the lock bit clear, a write may set the lock bit, so the lock can only be tightened. With the pin high, every field can be written, including clearing the lock bit.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the protect bits are 3'b111, the lock bit is 0 and the write-enable latch is 0, so a status read returns 0x1C when busy_i is 0. miso_oe is 0 while chip select is high.
- R2: A frame that carries opcode 0x06 or 0x50 and at least 8 clocks sets the write-enable latch when chip select rises. A status write (opcode 0x01) made while the latch is clear changes nothing.
- R3: A status write needs the write-enable latch and at least 16 clocks. When chip select rises, data bits 4:2 go to bp_o[2:0] and data bit 7 goes to the lock bit. A frame with fewer than 16 clocks leaves both unchanged.
- R4: When wp_n is low and the lock bit is 1 at the rise of chip select, a status write is ignored. bp_o and bpl_o keep their values.
- R5: When wp_n is low and the lock bit is 0, one status write can set the lock bit to 1 and change bp_o in the same operation.
- R6: When wp_n is high, status writes can change every field, including clearing the lock bit.
- R7: Any frame with opcode 0x01 and at least 8 clocks clears the write-enable latch when chip select rises. This holds whether the write was applied, refused or cut short.
- R8: A frame with any other opcode, or with fewer than 8 clocks, changes neither the protect bits, the lock bit nor the write-enable latch.
- R9: Opcode 0x05 starts a status read. The status byte is shifted out MSB first on falling clock edges and repeats for as long as chip select stays low. Its layout is: bit 0 busy_i, bit 1 write-enable latch, bits 4:2 the protect bits, bit 7 the lock bit, bits 6:5 zero. miso_oe is high only during the read data phase.
- R10: The controller works with the SPI clock idling low (mode 0) and idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; bus inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI serial data in |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| busy_i | input | 1 | Busy flag from the device, reported in status bit 0 |
| miso | output | 1 | SPI serial data out |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |
| bp_o | output | 3 | Block-protect bits to the rest of the device |
| bpl_o | output | 1 | Lock bit |

## Verification
A wrong protect or lock value reaches bp_o and bpl_o a few local clocks after chip select rises. A status read then shows it on the next data byte. A write-enable latch stuck high or low cannot be seen on those pins. It only shows through status bit 1 on a read, or through a later status write that lands or fails when it should not. The bench therefore reads the status back after every random frame. That exposes each latch error within one frame.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BP_W   = 3;

  localparam logic [BYTE_W-1:0] OP_WR_EN   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_STAT_EN = 8'h50;
  localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;

  localparam int unsigned STAT_BUSY  = 0;
  localparam int unsigned STAT_WEL   = 1;
  localparam int unsigned STAT_BP_LO = 2;
  localparam int unsigned STAT_LOCK  = 7;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_ENABLE,
    EV_WR_FULL,
    EV_WR_SHORT
  } frame_ev_e;
endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             rst_sync_n_o
);
  logic [STAGES-1:0] rst_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n_o = rst_pipe[STAGES-1];

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ssg_frame.sv
module ssg_frame
  import ssg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  output frame_ev_e         ev_o,
  output logic [BYTE_W-1:0] ev_data_o,
  output logic              rd_active_o,
  output logic              sck_fall_o
);
  localparam int unsigned CNT_MAX = 2 * BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              sck_d_q, cs_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shf_q, shf_d;
  logic [BYTE_W-1:0] op_q, op_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              rd_q, rd_d;
  frame_ev_e         ev_q, ev_d;
  logic              sck_rise, cs_rise, cs_fall;

  assign sck_rise   = sck_s_i & ~sck_d_q;
  assign sck_fall_o = ~sck_s_i & sck_d_q;
  assign cs_rise    = cs_s_i & ~cs_d_q;
  assign cs_fall    = ~cs_s_i & cs_d_q;

  always_comb begin
    cnt_d = cnt_q;
    shf_d = shf_q;
    op_d  = op_q;
    dat_d = dat_q;
    rd_d  = rd_q;
    ev_d  = EV_NONE;
    if (cs_fall) begin
      cnt_d = '0;
      shf_d = '0;
      op_d  = '0;
      rd_d  = 1'b0;
    end else if (!cs_s_i && sck_rise) begin
      shf_d = {shf_q[BYTE_W-2:0], mosi_s_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(BYTE_W - 1)) begin
        op_d = shf_d;
        if (shf_d == OP_STAT_RD) rd_d = 1'b1;
      end
      if (cnt_q == CNT_W'(2 * BYTE_W - 1)) dat_d = shf_d;
    end
    if (cs_rise) begin
      rd_d = 1'b0;
      if (cnt_q >= CNT_W'(BYTE_W)) begin
        if (op_q == OP_WR_EN || op_q == OP_STAT_EN) begin
          ev_d = EV_ENABLE;
        end else if (op_q == OP_STAT_WR) begin
          ev_d = (cnt_q >= CNT_W'(2 * BYTE_W)) ? EV_WR_FULL : EV_WR_SHORT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
      cnt_q   <= '0;
      shf_q   <= '0;
      op_q    <= '0;
      dat_q   <= '0;
      rd_q    <= 1'b0;
      ev_q    <= EV_NONE;
    end else begin
      sck_d_q <= sck_s_i;
      cs_d_q  <= cs_s_i;
      cnt_q   <= cnt_d;
      shf_q   <= shf_d;
      op_q    <= op_d;
      dat_q   <= dat_d;
      rd_q    <= rd_d;
      ev_q    <= ev_d;
    end
  end

  assign ev_o        = ev_q;
  assign ev_data_o   = dat_q;
  assign rd_active_o = rd_q;

  // R3: a command event is only issued once chip select is back high
  assert_event_after_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q != EV_NONE) |-> cs_s_i);
  // R9: the read phase begins exactly when the opcode byte is complete
  assert_read_after_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_q) |-> (cnt_q == CNT_W'(BYTE_W)));
endmodule

// File: rtl/ssg_regs.sv
module ssg_regs
  import ssg_pkg::*;
#(
  parameter logic [BP_W-1:0] RST_BP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_ev_e         ev_i,
  input  logic [BYTE_W-1:0] ev_data_i,
  input  logic              wp_s_i,
  input  logic              busy_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BP_W-1:0]   bp_o,
  output logic              bpl_o
);
  logic [BP_W-1:0] bp_q, bp_d;
  logic            bpl_q, bpl_d;
  logic            wel_q, wel_d;
  logic            wr_ok;
  logic            unused_data;

  assign unused_data = ^{ev_data_i[STAT_LOCK-1:STAT_BP_LO+BP_W], ev_data_i[STAT_BP_LO-1:0]};
  assign wr_ok = wel_q && (wp_s_i || !bpl_q);

  always_comb begin
    bp_d  = bp_q;
    bpl_d = bpl_q;
    wel_d = wel_q;
    unique case (ev_i)
      EV_ENABLE: wel_d = 1'b1;
      EV_WR_FULL: begin
        if (wr_ok) begin
          bp_d  = ev_data_i[STAT_BP_LO +: BP_W];
          bpl_d = ev_data_i[STAT_LOCK];
        end
        wel_d = 1'b0;
      end
      EV_WR_SHORT: wel_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q  <= RST_BP;
      bpl_q <= 1'b0;
      wel_q <= 1'b0;
    end else begin
      bp_q  <= bp_d;
      bpl_q <= bpl_d;
      wel_q <= wel_d;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STAT_BUSY] = busy_i;
    status_o[STAT_WEL]  = wel_q;
    status_o[STAT_BP_LO +: BP_W] = bp_q;
    status_o[STAT_LOCK] = bpl_q;
  end

  assign bp_o  = bp_q;
  assign bpl_o = bpl_q;

  // R4: pin low with lock set never releases the lock
  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bpl_q && !wp_s_i) |=> bpl_q);
  // R4: pin low with lock set freezes the protect bits
  assert_locked_bp_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bpl_q && !wp_s_i) |=> $stable(bp_q));
  // R7: every status-write frame drops the enable latch
  assert_wel_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_WR_FULL || ev_i == EV_WR_SHORT) |=> !wel_q);
  // R8: no event, no state change
  assert_quiet_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == EV_NONE) |=> $stable({bpl_q, bp_q, wel_q}));
endmodule

// File: rtl/ssg_tx.sv
module ssg_tx
  import ssg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active_i,
  input  logic              sck_fall_i,
  input  logic              cs_s_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bit_q, bit_d;

  always_comb begin
    idx_d = idx_q;
    bit_d = bit_q;
    if (!rd_active_i) begin
      idx_d = '0;
      bit_d = 1'b0;
    end else if (sck_fall_i) begin
      bit_d = status_i[IDX_W'(BYTE_W - 1) - idx_q];
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bit_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      bit_q <= bit_d;
    end
  end

  assign oe_o   = rd_active_i & ~cs_s_i;
  assign miso_o = bit_q & oe_o;

  // R9: after the last bit of a byte the shifter wraps to the MSB again
  assert_idx_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_i && sck_fall_i && idx_q == IDX_W'(BYTE_W - 1)) |=> (idx_q == '0));
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import ssg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            mosi,
  input  logic            wp_n,
  input  logic            busy_i,
  output logic            miso,
  output logic            miso_oe,
  output logic [BP_W-1:0] bp_o,
  output logic            bpl_o
);
  logic [3:0]        pins_s;
  logic              rst_int_n;
  frame_ev_e         ev;
  logic [BYTE_W-1:0] ev_data;
  logic              rd_active, sck_fall;
  logic [BYTE_W-1:0] status;

  ssg_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b0001)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .d_i          ({wp_n, mosi, sck, cs_n}),
    .q_o          (pins_s),
    .rst_sync_n_o (rst_int_n)
  );

  ssg_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_s_i      (pins_s[0]),
    .sck_s_i     (pins_s[1]),
    .mosi_s_i    (pins_s[2]),
    .ev_o        (ev),
    .ev_data_o   (ev_data),
    .rd_active_o (rd_active),
    .sck_fall_o  (sck_fall)
  );

  ssg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ev_i      (ev),
    .ev_data_i (ev_data),
    .wp_s_i    (pins_s[3]),
    .busy_i    (busy_i),
    .status_o  (status),
    .bp_o      (bp_o),
    .bpl_o     (bpl_o)
  );

  ssg_tx u_tx (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rd_active_i (rd_active),
    .sck_fall_i  (sck_fall),
    .cs_s_i      (pins_s[0]),
    .status_i    (status),
    .miso_o      (miso),
    .oe_o        (miso_oe)
  );
endmodule

// File: tb/sim_spi_status_guard.sv
module sim_spi_status_guard;
  localparam int HP = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_n, sck, mosi, wp_n, busy;
  logic miso, miso_oe, bpl;
  logic [2:0] bp;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [2:0] m_bp;
  logic m_bpl, m_wel;

  spi_status_guard u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .busy_i(busy), .miso(miso), .miso_oe(miso_oe),
    .bp_o(bp), .bpl_o(bpl)
  );

  function automatic logic [7:0] exp_status(input logic b);
    return {m_bpl, 2'b00, m_bp, m_wel, b};
  endfunction

  function automatic void model_frame(input logic [7:0] op, input logic [7:0] dat,
                                      input int nbits, input logic wp);
    if (nbits >= 8) begin
      if (op == 8'h06 || op == 8'h50) m_wel = 1'b1;
      else if (op == 8'h01) begin
        if (nbits >= 16 && m_wel && (wp || !m_bpl)) begin
          m_bp  = dat[4:2];
          m_bpl = dat[7];
        end
        m_wel = 1'b0;
      end
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [7:0] op, input logic [7:0] dat, input int nbits,
                          input bit mode3, output logic [15:0] rx, output logic oe_any);
    logic [15:0] tx;
    tx = {op, dat};
    rx = '0;
    oe_any = 1'b0;
    sck = mode3;
    wait_clk(HP);
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sck = 1'b0;
      mosi = (i < 16) ? tx[15 - i] : 1'b0;
      wait_clk(HP);
      if (i >= 8 && i < 24) rx[23 - i] = miso;
      oe_any = oe_any | miso_oe;
      sck = 1'b1;
      wait_clk(HP);
      if (!mode3) sck = 1'b0;
    end
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(4 * HP);
  endtask

  task automatic do_frame(input logic [7:0] op, input logic [7:0] dat, input int nbits,
                          input bit mode3);
    logic [15:0] rx;
    logic oe;
    spi_xfer(op, dat, nbits, mode3, rx, oe);
    model_frame(op, dat, nbits, wp_n);
    if (op != 8'h05 || nbits < 8) chk("R9 oe quiet outside read", {31'd0, oe}, 32'd0);
  endtask

  task automatic read_check(input string req, input bit mode3);
    logic [15:0] rx;
    logic oe;
    logic [7:0] e;
    e = exp_status(busy);
    spi_xfer(8'h05, 8'h00, 24, mode3, rx, oe);
    chk({req, " status byte 1"}, {24'd0, rx[15:8]}, {24'd0, e});
    chk({req, " status byte 2 (R9 repeat)"}, {24'd0, rx[7:0]}, {24'd0, e});
    chk({req, " bp_o"}, {29'd0, bp}, {29'd0, m_bp});
    chk({req, " bpl_o"}, {31'd0, bpl}, {31'd0, m_bpl});
    chk("R9 oe low after frame", {31'd0, miso_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] op, dat;
    int nb, k, r;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1; busy = 1'b0;
    m_bp = 3'b111; m_bpl = 1'b0; m_wel = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);

    // R1 reset state
    chk("R1 bp_o after reset", {29'd0, bp}, 32'd7);
    chk("R1 bpl_o after reset", {31'd0, bpl}, 32'd0);
    chk("R1 miso_oe after reset", {31'd0, miso_oe}, 32'd0);
    read_check("R1 reset status 0x1C", 1'b0);

    // R2 write without enable is dropped
    do_frame(8'h01, 8'h00, 16, 1'b0);
    read_check("R2 write without enable", 1'b0);
    chk("R2 bp kept", {29'd0, bp}, 32'd7);

    // R2 enable, R3 full write, R7 latch cleared
    do_frame(8'h06, 8'h00, 8, 1'b0);
    read_check("R2 enable 0x06 sets latch", 1'b0);
    do_frame(8'h01, 8'h00, 16, 1'b0);
    chk("R3 bp written to 0", {29'd0, bp}, 32'd0);
    read_check("R3 R7 after write", 1'b0);

    // R3 short frame, R7 latch still cleared
    do_frame(8'h50, 8'h00, 8, 1'b0);
    do_frame(8'h01, 8'h9C, 12, 1'b0);
    chk("R3 short frame keeps bp", {29'd0, bp}, 32'd0);
    read_check("R3 R7 short write", 1'b0);

    // R5 pin low, lock clear: set lock and bp together
    wp_n = 1'b0;
    do_frame(8'h06, 8'h00, 8, 1'b0);
    do_frame(8'h01, 8'h94, 16, 1'b0);
    chk("R5 bp set with lock", {29'd0, bp}, 32'd5);
    chk("R5 lock set", {31'd0, bpl}, 32'd1);

    // R4 pin low, lock set: write refused
    do_frame(8'h06, 8'h00, 8, 1'b0);
    do_frame(8'h01, 8'h00, 16, 1'b0);
    chk("R4 lock kept", {31'd0, bpl}, 32'd1);
    chk("R4 bp kept", {29'd0, bp}, 32'd5);
    read_check("R4 R7 refused write", 1'b0);

    // R6 R10 pin high, mode 3: lock cleared
    wp_n = 1'b1;
    do_frame(8'h50, 8'h00, 8, 1'b1);
    do_frame(8'h01, 8'h08, 16, 1'b1);
    chk("R6 R10 lock cleared", {31'd0, bpl}, 32'd0);
    chk("R6 R10 bp written", {29'd0, bp}, 32'd2);

    // R8 unknown opcode keeps latch
    do_frame(8'h06, 8'h00, 8, 1'b1);
    do_frame(8'hC3, 8'hFF, 16, 1'b1);
    busy = 1'b1;
    read_check("R8 R9 R10 unknown opcode, busy set", 1'b1);

    // random mix
    for (int it = 0; it < 120; it++) begin
      k = $urandom % 6;
      case (k)
        0: op = 8'h06;
        1: op = 8'h50;
        2, 3: op = 8'h01;
        4: op = 8'h05;
        default: begin
          op = 8'($urandom);
          if (op == 8'h06 || op == 8'h50 || op == 8'h01 || op == 8'h05) op = 8'hA5;
        end
      endcase
      r = $urandom % 8;
      if (r == 0) nb = $urandom % 8;
      else if (r == 1) nb = 8 + ($urandom % 8);
      else nb = 16;
      dat = 8'($urandom);
      wp_n = 1'($urandom);
      busy = 1'($urandom);
      do_frame(op, dat, nb, 1'($urandom));
      read_check("R2-R10 random", 1'($urandom));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule